// File: doc/BRIEF.md
# Audio Sample FIFO with Level Interrupt

This block buffers 16-bit audio samples between a decimation filter and a processor. The filter side presents one sample per output period on a valid strobe. The processor drains the buffer through a small register interface: each read of the data register hands back the oldest stored sample and removes it. When there are no stored samples, a read hands back the most recently removed sample again rather than stale storage.

Two service outputs tell the processor or a DMA engine when to drain the buffer. The interrupt output rises when the fill count is strictly greater than a programmable 3-bit threshold and the interrupt is enabled. The DMA request output is high while samples are present and DMA service is enabled. A run bit gates the whole path. While run is low, the conversion-enable output is low, the buffer pointers and the overflow flag are held cleared, and incoming samples are discarded. The buffer holds eight words, so every threshold value from 0 to 7 can be reached.

Register map, selected by `reg_addr`:

- 0: sample data. Reading it removes a sample.
- 1: interrupt setup. The threshold is in bits 2:0 and the interrupt enable is bit 31.
- 2: run, in bit 0.
- 3: DMA enable, in bit 0.
- 4: status. The fill count is in bits 3:0 and the sticky overflow flag is bit 8.

Register writes take effect at the clock edge. `reg_rdata` is combinational from `reg_addr`.

Top module: `smpl_fifo_irq`

## Requirements
- R1: After reset the buffer is empty, run, DMA enable, interrupt enable and threshold are 0, `irq`, `dma_req` and `conv_run` are low, and a read of address 0 returns 0.
- R2: With run set, a read strobe at address 0 returns the oldest stored sample in the same cycle and removes it at the clock edge, so samples come out in arrival order.
- R3: A read strobe at address 0 while the buffer is empty returns the last removed sample and leaves the fill count at 0.
- R4: At address 0 the sample occupies bits 15:0 and bits 31:16 read as 0.
- R5: `irq` is high exactly when the interrupt enable (address 1 bit 31) is 1 and the fill count is greater than the threshold (address 1 bits 2:0).
- R6: `dma_req` is high exactly when the DMA enable (address 3 bit 0) is 1 and the fill count is not 0.
- R7: While run (address 2 bit 0) is 0, `conv_run` is low, the fill count and the overflow flag read 0 one cycle later, and pushed samples are discarded.
- R8: A push into a full buffer (8 words) with no read in the same cycle is discarded and sets the overflow flag (address 4 bit 8). The flag stays set until run is cleared.
- R9: A push and a read of address 0 in the same cycle on a non-empty buffer leave the fill count unchanged. This holds when the buffer is full, in which case the pushed word is kept.
- R10: Address 4 bits 3:0 report the current fill count, from 0 to 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_vld | input | 1 | Sample push strobe from the filter |
| smp_data | input | 16 | Sample value to push |
| reg_addr | input | 3 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (address 0 removes a sample) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for the selected address |
| irq | output | 1 | Level interrupt request |
| dma_req | output | 1 | DMA service request |
| conv_run | output | 1 | Conversion enable toward the filter |

## Verification
The hardest state to reach is a read and a push landing in the same cycle while the buffer is exactly full. In that case the push must be accepted only because a word is also leaving, and the overflow flag must stay clear. Directed steps fill the buffer to eight words, overflow it once, and then issue a combined push and read, confirming the count with a status read.

Random traffic then mixes push rates, drain reads, threshold changes and occasional run drops. This sweeps the interrupt comparison across every threshold against every fill level, and it also covers reads of an empty buffer after various last words.

// File: rtl/smpl_pkg.sv
package smpl_pkg;

    localparam int SMPL_W     = 16;
    localparam int FIFO_DEPTH = 8;
    localparam int LVL_W      = 3;
    localparam int BUS_W      = 32;
    localparam int ADDR_W     = 3;
    localparam int PTR_W      = $clog2(FIFO_DEPTH);
    localparam int CNT_W      = PTR_W + 1;
    localparam int IE_BIT     = 31;
    localparam int OVF_BIT    = 8;

    typedef enum logic [ADDR_W-1:0] {
        ADR_DATA   = 3'd0,
        ADR_IRQCFG = 3'd1,
        ADR_RUN    = 3'd2,
        ADR_DMA    = 3'd3,
        ADR_STATUS = 3'd4
    } reg_adr_e;

    typedef struct packed {
        logic             irq_en;
        logic [LVL_W-1:0] level;
        logic             dma_en;
        logic             run;
    } ctrl_t;

    typedef struct packed {
        logic [CNT_W-1:0]  fill;
        logic              ovf;
        logic [SMPL_W-1:0] head;
    } ring_stat_t;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        if (p == PTR_W'(FIFO_DEPTH - 1))
            return '0;
        return p + PTR_W'(1);
    endfunction

    function automatic logic above_level(input logic [CNT_W-1:0] fill,
                                         input logic [LVL_W-1:0] lvl);
        return fill > CNT_W'(lvl);
    endfunction

endpackage

// File: rtl/smpl_regs.sv
module smpl_regs
    import smpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [BUS_W-1:0]  wdata,
    output ctrl_t             ctrl
);

    wire unused_wbits = ^{wdata[IE_BIT-1:LVL_W]};

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr) begin
            case (reg_adr_e'(addr))
                ADR_IRQCFG: begin
                    ctrl.level  <= wdata[LVL_W-1:0];
                    ctrl.irq_en <= wdata[IE_BIT];
                end
                ADR_RUN: ctrl.run    <= wdata[0];
                ADR_DMA: ctrl.dma_en <= wdata[0];
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/smpl_ring.sv
module smpl_ring
    import smpl_pkg::*;
#(
    parameter int DW    = SMPL_W,
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          push_req,
    input  logic [DW-1:0] push_data,
    input  logic          pop_req,
    output logic          push_ok,
    output logic          pop_ok,
    output ring_stat_t    stat
);

    localparam int PW = $clog2(DEPTH);
    localparam int CW = PW + 1;

    logic [DW-1:0] mem [DEPTH];
    logic [PW-1:0] wptr, rptr;
    logic [CW-1:0] fill;
    logic          ovf;
    logic [DW-1:0] last_word;
    logic          empty, full, drop;

    assign empty   = (fill == '0);
    assign full    = (fill == CW'(DEPTH));
    assign pop_ok  = pop_req && !clear && !empty;
    assign push_ok = push_req && !clear && (!full || pop_ok);
    assign drop    = push_req && !clear && !push_ok;

    always_ff @(posedge clk) begin
        if (push_ok)
            mem[wptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            wptr <= '0;
            rptr <= '0;
            fill <= '0;
            ovf  <= 1'b0;
        end else begin
            if (push_ok)
                wptr <= ptr_next(wptr);
            if (pop_ok)
                rptr <= ptr_next(rptr);
            case ({push_ok, pop_ok})
                2'b10:   fill <= fill + CW'(1);
                2'b01:   fill <= fill - CW'(1);
                default: fill <= fill;
            endcase
            if (drop)
                ovf <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            last_word <= '0;
        else if (pop_ok)
            last_word <= mem[rptr];
    end

    always_comb begin
        stat      = '0;
        stat.fill = fill;
        stat.ovf  = ovf;
        stat.head = empty ? last_word : mem[rptr];
    end

endmodule

// File: rtl/smpl_req.sv
module smpl_req
    import smpl_pkg::*;
(
    input  ctrl_t            ctrl,
    input  logic [CNT_W-1:0] fill,
    output logic             irq,
    output logic             dma_req
);

    always_comb begin
        irq     = ctrl.irq_en && above_level(fill, ctrl.level);
        dma_req = ctrl.dma_en && (fill != '0);
    end

endmodule

// File: rtl/smpl_fifo_irq.sv
module smpl_fifo_irq
    import smpl_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              smp_vld,
    input  logic [SMPL_W-1:0] smp_data,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [BUS_W-1:0]  reg_wdata,
    output logic [BUS_W-1:0]  reg_rdata,
    output logic              irq,
    output logic              dma_req,
    output logic              conv_run
);

    ctrl_t            ctrl;
    ring_stat_t       stat;
    logic             pop_req, push_ok, pop_ok;
    logic [CNT_W-1:0] fill_cnt;

    assign pop_req  = reg_rd && (reg_adr_e'(reg_addr) == ADR_DATA);
    assign fill_cnt = stat.fill;
    assign conv_run = ctrl.run;

    smpl_regs u_regs (
        .clk   (clk),
        .rst   (rst),
        .wr    (reg_wr),
        .addr  (reg_addr),
        .wdata (reg_wdata),
        .ctrl  (ctrl)
    );

    smpl_ring #(.DW(SMPL_W), .DEPTH(FIFO_DEPTH)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .clear     (!ctrl.run),
        .push_req  (smp_vld),
        .push_data (smp_data),
        .pop_req   (pop_req),
        .push_ok   (push_ok),
        .pop_ok    (pop_ok),
        .stat      (stat)
    );

    smpl_req u_req (
        .ctrl    (ctrl),
        .fill    (fill_cnt),
        .irq     (irq),
        .dma_req (dma_req)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_adr_e'(reg_addr))
            ADR_DATA:   reg_rdata[SMPL_W-1:0] = stat.head;
            ADR_IRQCFG: begin
                reg_rdata[LVL_W-1:0] = ctrl.level;
                reg_rdata[IE_BIT]    = ctrl.irq_en;
            end
            ADR_RUN:    reg_rdata[0] = ctrl.run;
            ADR_DMA:    reg_rdata[0] = ctrl.dma_en;
            ADR_STATUS: begin
                reg_rdata[CNT_W-1:0] = stat.fill;
                reg_rdata[OVF_BIT]   = stat.ovf;
            end
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/smpl_fifo_chk.sv
module smpl_fifo_chk
    import smpl_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] fill,
    input logic             ovf,
    input logic             irq,
    input logic             dma_req,
    input logic             run,
    input logic             push_req,
    input logic             pop_req,
    input logic             push_ok,
    input logic             pop_ok
);

    assert_fill_bound_R10: assert property (@(posedge clk) disable iff (rst)
        fill <= CNT_W'(FIFO_DEPTH));

    assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (rst)
        irq |-> (fill != '0));

    assert_dma_needs_data_R6: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> (fill != '0));

    assert_idle_clears_R7: assert property (@(posedge clk) disable iff (rst)
        !run |=> (fill == '0) && !ovf);

    assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        $fell(ovf) |-> !$past(run));

    assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
        (run && push_req && (fill == CNT_W'(FIFO_DEPTH)) && !pop_req) |=> ovf);

    assert_swap_holds_R9: assert property (@(posedge clk) disable iff (rst)
        (push_ok && pop_ok) |=> $stable(fill));

    assert_empty_read_R3: assert property (@(posedge clk) disable iff (rst)
        (pop_req && (fill == '0) && !push_req) |=> (fill == '0));

endmodule

bind smpl_fifo_irq smpl_fifo_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .fill     (fill_cnt),
    .ovf      (stat.ovf),
    .irq      (irq),
    .dma_req  (dma_req),
    .run      (conv_run),
    .push_req (smp_vld),
    .pop_req  (pop_req),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok)
);

// File: tb/sim_smpl_fifo_irq.sv
`timescale 1ns/1ps
module sim_smpl_fifo_irq;

    logic        clk = 1'b0;
    logic        rst;
    logic        smp_vld;
    logic [15:0] smp_data;
    logic [2:0]  reg_addr;
    logic        reg_wr, reg_rd;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic        irq, dma_req, conv_run;

    int errors = 0;
    int checks = 0;
    bit done   = 0;

    logic [15:0] q[$];
    logic [15:0] m_last = 16'h0;
    logic [2:0]  m_lvl  = 3'd0;
    bit          m_ie   = 0;
    bit          m_dma  = 0;
    bit          m_run  = 0;
    bit          m_ovf  = 0;
    logic [31:0] cap;

    always #4 clk = ~clk;

    smpl_fifo_irq u0 (
        .clk(clk), .rst(rst), .smp_vld(smp_vld), .smp_data(smp_data),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .dma_req(dma_req), .conv_run(conv_run)
    );

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        return {23'h0, m_ovf, 4'h0, 4'(q.size())};
    endfunction

    task automatic step(input bit p, input logic [15:0] d, input bit rd,
                        input bit wr, input logic [2:0] a, input logic [31:0] wd);
        logic [31:0] e;
        bit pop_e;
        @(negedge clk);
        smp_vld = p; smp_data = d; reg_rd = rd; reg_wr = wr;
        reg_addr = a; reg_wdata = wd;
        #1;
        cap = reg_rdata;
        chk(irq == (m_ie && (q.size() > int'(m_lvl))), "R5", 32'(irq), 32'(m_ie && (q.size() > int'(m_lvl))));
        chk(dma_req == (m_dma && q.size() != 0), "R6", 32'(dma_req), 32'(m_dma && q.size() != 0));
        chk(conv_run == m_run, "R7", 32'(conv_run), 32'(m_run));
        if (rd || !wr) begin
            case (a)
                3'd0: begin
                    e = {16'h0, (q.size() != 0) ? q[0] : m_last};
                    chk(reg_rdata[15:0] == e[15:0], (q.size() != 0) ? "R2" : "R3", reg_rdata, e);
                    chk(reg_rdata[31:16] == 16'h0, "R4", reg_rdata, e);
                end
                3'd1: begin
                    e = {m_ie, 28'h0, m_lvl};
                    chk(reg_rdata == e, "R5", reg_rdata, e);
                end
                3'd4: begin
                    e = exp_status();
                    chk(reg_rdata[3:0] == e[3:0], "R10", reg_rdata, e);
                    chk(reg_rdata[8] == e[8], "R8", reg_rdata, e);
                end
                default: ;
            endcase
        end
        pop_e = rd && (a == 3'd0) && m_run && (q.size() != 0);
        if (!m_run) begin
            q.delete();
            m_ovf = 0;
        end else begin
            if (pop_e) begin
                m_last = q[0];
                void'(q.pop_front());
            end
            if (p) begin
                if (q.size() < 8) q.push_back(d);
                else m_ovf = 1;
            end
        end
        if (wr) begin
            case (a)
                3'd1: begin m_lvl = wd[2:0]; m_ie = wd[31]; end
                3'd2: m_run = wd[0];
                3'd3: m_dma = wd[0];
                default: ;
            endcase
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd2024));
        rst = 1; smp_vld = 0; smp_data = 0; reg_addr = 0;
        reg_wr = 0; reg_rd = 0; reg_wdata = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state
        #1;
        chk(irq == 0 && dma_req == 0 && conv_run == 0, "R1",
            {29'h0, irq, dma_req, conv_run}, 32'h0);
        chk(reg_rdata == 32'h0, "R1", reg_rdata, 32'h0);
        step(0, 0, 1, 0, 3'd4, 0);
        chk(cap == 32'h0, "R1", cap, 32'h0);

        // Enable, threshold 3 with interrupt, DMA on
        step(0, 0, 0, 1, 3'd2, 32'h1);
        step(0, 0, 0, 1, 3'd1, 32'h8000_0003);
        step(0, 0, 0, 1, 3'd3, 32'h1);
        for (int i = 0; i < 9; i++) step(1, 16'hA000 + 16'(i), 0, 0, 3'd7, 0);
        step(0, 0, 1, 0, 3'd4, 0);
        chk(cap == 32'h0000_0108, "R8", cap, 32'h0000_0108);

        // R9: push and read together while full
        step(1, 16'hBEEF, 1, 0, 3'd0, 0);
        chk(cap == 32'h0000_A000, "R2", cap, 32'h0000_A000);
        step(0, 0, 1, 0, 3'd4, 0);
        chk(cap[3:0] == 4'd8, "R9", cap, 32'h0000_0108);

        // Drain in order, then read empty twice
        for (int i = 0; i < 8; i++) step(0, 0, 1, 0, 3'd0, 0);
        step(0, 0, 1, 0, 3'd0, 0);
        chk(cap == 32'h0000_BEEF, "R3", cap, 32'h0000_BEEF);
        step(0, 0, 1, 0, 3'd0, 0);
        chk(cap == 32'h0000_BEEF, "R3", cap, 32'h0000_BEEF);

        // R7: dropping run clears and blocks pushes
        for (int i = 0; i < 3; i++) step(1, 16'h1230 + 16'(i), 0, 0, 3'd7, 0);
        step(0, 0, 0, 1, 3'd2, 32'h0);
        step(1, 16'h5555, 0, 0, 3'd7, 0);
        step(1, 16'h6666, 1, 0, 3'd4, 0);
        chk(cap == 32'h0, "R7", cap, 32'h0);
        step(0, 0, 0, 1, 3'd2, 32'h1);
        step(0, 0, 1, 0, 3'd4, 0);
        chk(cap == 32'h0, "R7", cap, 32'h0);

        // Random traffic
        for (int n = 0; n < 5000; n++) begin
            int op;
            bit p;
            op = int'($urandom_range(0, 99));
            p  = ($urandom_range(0, 99) < 45);
            if (op < 50)      step(p, 16'($urandom), 0, 0, 3'd7, 0);
            else if (op < 80) step(p, 16'($urandom), 1, 0, 3'd0, 0);
            else if (op < 88) step(p, 16'($urandom), 1, 0, 3'd4, 0);
            else if (op < 92) step(p, 16'($urandom), 1, 0, 3'd1, 0);
            else if (op < 96) step(p, 16'($urandom), 0, 1, 3'd1,
                                   {1'($urandom), 28'h0, 3'($urandom)});
            else if (op < 98) step(p, 16'($urandom), 0, 1, 3'd3, 32'($urandom_range(0, 1)));
            else              step(p, 16'($urandom), 0, 1, 3'd2, 32'($urandom_range(0, 3) != 0));
        end

        finish_run();
    end

endmodule